// File: doc/BRIEF.md
# VGA Planar Read Path

This block answers byte-wide CPU reads from a 64 KB graphics window. Video memory is four byte-wide planes held side by side in 32-bit words: plane n sits in bits 8n+7 down to 8n. The block decodes one of three addressing schemes from the mode register values it is given, fetches a word from a synchronous RAM, and returns one byte.

In planar addressing each read also loads a 32-bit latch with the whole fetched word. The returned byte is either one plane of that word (plane select) or a colour-compare result. A colour-compare result marks the pixels whose plane bits match a 4-bit colour, with planes marked don't-care left out. The latch is exported so that a write path can use it. That write path also owns the RAM write port, which this block exposes.

Requests use a valid/ready handshake, with one read in flight at a time. The response comes back one cycle after acceptance. The mode register values are sampled when a request is accepted.

Top module: `vga_rd_path`

## Requirements
- R1: The window offset is the low 17 bits of `req_addr_i`. An offset of 0x10000 or above returns 0xFF, reads no memory and leaves `latch_o` unchanged. Address bits above bit 16 are ignored.
- R2: When `seq_memmode_i` bit 3 is set, the mode is chain-4. The result is byte lane offset[1:0] of RAM word offset[15:2].
- R3: When `gfx_mode_i` bit 4 is set and chain-4 is off, the mode is odd/even. The plane is {`gfx_plane_i` bit 1, offset bit 0}. The result is that plane's byte of RAM word offset[15:1].
- R4: When neither chain-4 nor odd/even is selected, the mode is planar. RAM word offset[15:0] is loaded into the latch. `latch_o` shows the new word in the response cycle and keeps it until the next planar read.
- R5: Planar with `gfx_mode_i` bit 3 clear is read mode 0. It returns the latch byte of plane `gfx_plane_i[1:0]`.
- R6: Planar with `gfx_mode_i` bit 3 set is read mode 1. Each nibble bit k is expanded to an all-ones or all-zeros byte for plane k. The block computes (latch XOR expand(`gfx_cmp_i[3:0]`)) AND expand(`gfx_dontcare_i[3:0]`), ORs the four plane bytes together and returns the complement. With all planes don't-care (nibble 0) the result is 0xFF.
- R7: `req_ready_o` is high when idle. An accepted request gives `rsp_valid_o` high for exactly the next cycle, with `req_ready_o` low in that cycle.
- R8: Chain-4 and odd/even reads do not change `latch_o`.
- R9: The mode inputs and the address are sampled at acceptance. Changing them during the response cycle has no effect on `rsp_data_o`.
- R10: A write with `wr_en_i` updates only the byte lanes of RAM word `wr_word_i` whose `wr_strb_i` bit is set (bit n for plane n). RAM word indices are taken modulo 2^MEM_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_addr_i | input | ADDR_W | Byte address; low 17 bits form the offset |
| seq_memmode_i | input | 8 | Sequencer memory mode; bit 3 selects chain-4 |
| gfx_mode_i | input | 8 | Graphics mode; bit 4 odd/even, bit 3 read mode 1 |
| gfx_plane_i | input | 8 | Read plane select, bits 1:0 |
| gfx_cmp_i | input | 8 | Colour-compare nibble, bits 3:0 |
| gfx_dontcare_i | input | 8 | Colour don't-care nibble, bits 3:0 |
| rsp_valid_o | output | 1 | Response valid |
| rsp_data_o | output | 8 | Read byte |
| latch_o | output | 32 | Four-plane latch for the write path |
| wr_en_i | input | 1 | RAM write enable |
| wr_word_i | input | MEM_AW | RAM write word index |
| wr_data_i | input | 32 | RAM write data |
| wr_strb_i | input | 4 | Per-plane byte write strobe |

## Verification
Memory is filled with random words. Random mode settings and offsets then pick among chain-4, odd/even, plane select and colour-compare, so a wrong mode priority or lane choice shows up as a wrong byte. Directed colour-compare words with all-equal, all-different and all-don't-care planes separate the XOR, AND and final complement steps. Out-of-window offsets and offsets with high address bits set tell apart the 17-bit reduction and the 0xFF path. Mode inputs are changed during each response, and partial-strobe writes are read back lane by lane, which exposes late sampling and strobe mix-ups.

// File: rtl/vga_rd_pkg.sv
package vga_rd_pkg;

  typedef enum logic [1:0] {
    ACC_PLANAR  = 2'd0,
    ACC_CHAIN4  = 2'd1,
    ACC_ODDEVEN = 2'd2
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic       oob;
    logic [1:0] lane;
    logic       rmode1;
    logic [3:0] cmp;
    logic [3:0] dc;
  } rd_ctx_t;

  localparam int unsigned PLANES = 4;

  function automatic logic [31:0] expand_nib(input logic [3:0] n);
    logic [31:0] r;
    for (int i = 0; i < PLANES; i++) r[8*i +: 8] = {8{n[i]}};
    return r;
  endfunction

endpackage

// File: rtl/vga_rd_decode.sv
module vga_rd_decode
  import vga_rd_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic [16:0]       off_i,
  input  logic [7:0]        seq_memmode_i,
  input  logic [7:0]        gfx_mode_i,
  input  logic [7:0]        gfx_plane_i,
  output acc_kind_e         kind_o,
  output logic              oob_o,
  output logic [1:0]        lane_o,
  output logic [MEM_AW-1:0] word_o
);
  logic [15:0] word_full;

  assign oob_o = off_i[16];

  always_comb begin
    if (seq_memmode_i[3]) begin
      kind_o    = ACC_CHAIN4;
      lane_o    = off_i[1:0];
      word_full = {2'b00, off_i[15:2]};
    end else if (gfx_mode_i[4]) begin
      kind_o    = ACC_ODDEVEN;
      lane_o    = {gfx_plane_i[1], off_i[0]};
      word_full = {1'b0, off_i[15:1]};
    end else begin
      kind_o    = ACC_PLANAR;
      lane_o    = gfx_plane_i[1:0];
      word_full = off_i[15:0];
    end
  end

  // window larger than RAM: word index wraps
  assign word_o = word_full[MEM_AW-1:0];

  logic unused_hi;
  assign unused_hi = ^{word_full[15:MEM_AW], seq_memmode_i[7:4], seq_memmode_i[2:0],
                       gfx_mode_i[7:5], gfx_mode_i[3:0], gfx_plane_i[7:2]};

endmodule

// File: rtl/vga_rd_ram.sv
module vga_rd_ram #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [3:0]    wstrb_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] mem_q [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i && wstrb_i[g]) mem_q[waddr_i] <= wdata_i[8*g +: 8];
      if (re_i) rd_q <= mem_q[raddr_i];
    end

    assign rdata_o[8*g +: 8] = rd_q;
  end

endmodule

// File: rtl/vga_rd_result.sv
module vga_rd_result
  import vga_rd_pkg::*;
(
  input  logic [31:0] word_i,
  input  acc_kind_e   kind_i,
  input  logic [1:0]  lane_i,
  input  logic        rmode1_i,
  input  logic [3:0]  cmp_i,
  input  logic [3:0]  dc_i,
  output logic [7:0]  byte_o
);
  logic [31:0] diff;
  logic [7:0]  fold;
  logic [7:0]  lane_byte;

  assign lane_byte = word_i[8*lane_i +: 8];
  assign diff      = (word_i ^ expand_nib(cmp_i)) & expand_nib(dc_i);

  always_comb begin
    fold = '0;
    for (int p = 0; p < PLANES; p++) fold |= diff[8*p +: 8];
  end

  always_comb begin
    if (kind_i == ACC_PLANAR && rmode1_i) byte_o = ~fold;
    else                                  byte_o = lane_byte;
  end

endmodule

// File: rtl/vga_rd_path.sv
module vga_rd_path
  import vga_rd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int MEM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        seq_memmode_i,
  input  logic [7:0]        gfx_mode_i,
  input  logic [7:0]        gfx_plane_i,
  input  logic [7:0]        gfx_cmp_i,
  input  logic [7:0]        gfx_dontcare_i,
  output logic              rsp_valid_o,
  output logic [7:0]        rsp_data_o,
  output logic [31:0]       latch_o,
  input  logic              wr_en_i,
  input  logic [MEM_AW-1:0] wr_word_i,
  input  logic [31:0]       wr_data_i,
  input  logic [3:0]        wr_strb_i
);
  logic              pend_q;
  logic              req_fire;
  logic              ram_re;
  logic              ld_now;
  rd_ctx_t           ctx_d, ctx_q;
  acc_kind_e         dec_kind;
  logic              dec_oob;
  logic [1:0]        dec_lane;
  logic [MEM_AW-1:0] dec_word;
  logic [31:0]       ram_rdata;
  logic [31:0]       latch_q;
  logic [7:0]        res_byte;

  assign req_ready_o = !pend_q;
  assign req_fire    = req_valid_i && req_ready_o;

  vga_rd_decode #(.MEM_AW(MEM_AW)) u_dec (
    .off_i        (req_addr_i[16:0]),
    .seq_memmode_i(seq_memmode_i),
    .gfx_mode_i   (gfx_mode_i),
    .gfx_plane_i  (gfx_plane_i),
    .kind_o       (dec_kind),
    .oob_o        (dec_oob),
    .lane_o       (dec_lane),
    .word_o       (dec_word)
  );

  always_comb begin
    ctx_d        = '0;
    ctx_d.kind   = dec_kind;
    ctx_d.oob    = dec_oob;
    ctx_d.lane   = dec_lane;
    ctx_d.rmode1 = gfx_mode_i[3];
    ctx_d.cmp    = gfx_cmp_i[3:0];
    ctx_d.dc     = gfx_dontcare_i[3:0];
  end

  assign ram_re = req_fire && !dec_oob;

  vga_rd_ram #(.AW(MEM_AW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (wr_en_i),
    .waddr_i(wr_word_i),
    .wdata_i(wr_data_i),
    .wstrb_i(wr_strb_i),
    .re_i   (ram_re),
    .raddr_i(dec_word),
    .rdata_o(ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ctx_q  <= '0;
    end else begin
      pend_q <= req_fire;
      if (req_fire) ctx_q <= ctx_d;
    end
  end

  assign ld_now = pend_q && ctx_q.kind == ACC_PLANAR && !ctx_q.oob;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     latch_q <= '0;
    else if (ld_now) latch_q <= ram_rdata;
  end

  // latch visible in the cycle its word arrives
  assign latch_o = ld_now ? ram_rdata : latch_q;

  vga_rd_result u_res (
    .word_i  (ram_rdata),
    .kind_i  (ctx_q.kind),
    .lane_i  (ctx_q.lane),
    .rmode1_i(ctx_q.rmode1),
    .cmp_i   (ctx_q.cmp),
    .dc_i    (ctx_q.dc),
    .byte_o  (res_byte)
  );

  assign rsp_valid_o = pend_q;
  assign rsp_data_o  = ctx_q.oob ? 8'hFF : res_byte;

  logic unused_in;
  assign unused_in = ^{req_addr_i[ADDR_W-1:17], gfx_cmp_i[7:4], gfx_dontcare_i[7:4]};

  // R7
  rsp_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o);

  // R7
  single_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R1
  oob_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_addr_i[16] |=> rsp_data_o == 8'hFF && $stable(latch_o));

  // R4
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> $stable(latch_o));

  // R8
  latch_nonplanar_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && ctx_q.kind != ACC_PLANAR |-> $stable(latch_o));

  // R6
  rm1_all_dc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !ctx_q.oob && ctx_q.kind == ACC_PLANAR && ctx_q.rmode1 && ctx_q.dc == 4'h0
    |-> rsp_data_o == 8'hFF);

endmodule

// File: tb/sim_vga_rd_path.sv
module sim_vga_rd_path;
  localparam int ADDR_W = 20;
  localparam int MEM_AW = 10;
  localparam int WORDS  = 1 << MEM_AW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0]        sr4 = '0, gr5 = '0, gr4 = '0, gr2 = '0, gr7 = '0;
  logic              rsp_valid;
  logic [7:0]        rsp_data;
  logic [31:0]       latch;
  logic              wr_en = 1'b0;
  logic [MEM_AW-1:0] wr_word = '0;
  logic [31:0]       wr_data = '0;
  logic [3:0]        wr_strb = '0;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] mdl_mem [WORDS];
  logic [31:0] mdl_latch = '0;

  always #4 clk = ~clk;

  vga_rd_path #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .seq_memmode_i(sr4), .gfx_mode_i(gr5), .gfx_plane_i(gr4),
    .gfx_cmp_i(gr2), .gfx_dontcare_i(gr7),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .latch_o(latch),
    .wr_en_i(wr_en), .wr_word_i(wr_word), .wr_data_i(wr_data), .wr_strb_i(wr_strb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected byte from the requirements; updates mdl_latch on planar reads
  task automatic model(input logic [ADDR_W-1:0] a, output logic [7:0] b);
    logic [16:0] off;
    logic [31:0] w, x;
    logic [7:0]  f;
    off = a[16:0];
    if (off >= 17'h10000) begin
      b = 8'hFF;
    end else if (sr4[3]) begin
      w = mdl_mem[(off >> 2) % WORDS];
      b = w[8*off[1:0] +: 8];
    end else if (gr5[4]) begin
      w = mdl_mem[(off >> 1) % WORDS];
      b = w[8*{gr4[1], off[0]} +: 8];
    end else begin
      mdl_latch = mdl_mem[off % WORDS];
      if (!gr5[3]) begin
        b = mdl_latch[8*gr4[1:0] +: 8];
      end else begin
        f = 8'h00;
        for (int p = 0; p < 4; p++) begin
          x[8*p +: 8] = (mdl_latch[8*p +: 8] ^ {8{gr2[p]}}) & {8{gr7[p]}};
          f = f | x[8*p +: 8];
        end
        b = ~f;
      end
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input logic [3:0] s);
    wr_en = 1'b1; wr_word = idx[MEM_AW-1:0]; wr_data = d; wr_strb = s;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    for (int p = 0; p < 4; p++) if (s[p]) mdl_mem[idx][8*p +: 8] = d[8*p +: 8];
  endtask

  // called at a negedge with modes already set
  task automatic rd(input string tag, input logic [ADDR_W-1:0] a);
    logic [7:0]  eb;
    logic [31:0] prev_latch;
    prev_latch = latch;
    model(a, eb);
    chk({tag, " R7 ready idle"}, {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    // R9: scramble inputs during response
    req_addr = $urandom; sr4 = $urandom; gr5 = $urandom; gr4 = $urandom; gr2 = $urandom; gr7 = $urandom;
    #1;
    chk({tag, " R7 rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
    chk({tag, " R7 ready busy"}, {31'b0, req_ready}, 32'd0);
    chk({tag, " data R9"}, {24'b0, rsp_data}, {24'b0, eb});
    chk({tag, " latch R4 R8"}, latch, mdl_latch);
    @(negedge clk);
    chk({tag, " R7 rsp one cycle"}, {31'b0, rsp_valid}, 32'd0);
    chk({tag, " latch hold R4"}, latch, mdl_latch);
    if (mdl_latch === prev_latch) chk({tag, " latch unchanged R1 R8"}, latch, prev_latch);
  endtask

  task automatic set_modes(input logic [7:0] s4, g5, g4, g2, g7);
    sr4 = s4; gr5 = g5; gr4 = g4; gr2 = g2; gr7 = g7;
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < WORDS; i++) mdl_mem[i] = '0;
    #20;
    @(negedge clk);
    chk("reset R7 ready", {31'b0, req_ready}, 32'd1);
    chk("reset R7 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("reset latch", latch, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < WORDS; i++) wr(i, $urandom, 4'hF);

    // R2 chain-4 lanes
    set_modes(8'h08, 8'h00, 8'h00, 8'h00, 8'h00);
    for (int l = 0; l < 4; l++) begin
      set_modes(8'h08, 8'h00, 8'h00, 8'h00, 8'h00);
      rd("R2 chain4", 20'h00040 + 20'(l));
    end
    // chain-4 wins over odd/even
    set_modes(8'hFF, 8'h10, 8'h02, 8'h00, 8'h00); rd("R2 chain4 priority", 20'h01235);

    // R3 odd/even plane combos
    for (int k = 0; k < 4; k++) begin
      set_modes(8'h00, 8'h10, {6'b0, k[1], 1'b0}, 8'h00, 8'h00);
      rd("R3 oddeven", 20'h00200 + 20'(k[0]));
    end

    // R5 read mode 0 each plane
    for (int k = 0; k < 4; k++) begin
      set_modes(8'h00, 8'h00, 8'(k), 8'h00, 8'h00);
      rd("R5 rmode0", 20'h00123);
    end

    // R6 colour compare directed
    wr(7, 32'h00FF00FF, 4'hF);
    set_modes(8'h00, 8'h08, 8'h00, 8'h05, 8'h0F); rd("R6 all match", 20'h00007);
    set_modes(8'h00, 8'h08, 8'h00, 8'h0A, 8'h0F); rd("R6 none match", 20'h00007);
    set_modes(8'h00, 8'h08, 8'h00, 8'h0A, 8'h00); rd("R6 all dontcare", 20'h00007);
    wr(9, 32'hF00FCC33, 4'hF);
    set_modes(8'h00, 8'h08, 8'h00, 8'h03, 8'h06); rd("R6 partial dc", 20'h00009);

    // R10 strobes
    wr(20, 32'h11223344, 4'hF);
    wr(20, 32'hAABBCCDD, 4'b0101);
    for (int l = 0; l < 4; l++) begin
      set_modes(8'h08, 8'h00, 8'h00, 8'h00, 8'h00);
      rd("R10 strobe", 20'(80 + l));
    end
    set_modes(8'h00, 8'h00, 8'h00, 8'h00, 8'h00); rd("R10 wrap", 20'(20 + WORDS));

    // R1 out of window, high bits ignored
    set_modes(8'h00, 8'h00, 8'h01, 8'h00, 8'h00); rd("R1 planar load", 20'h00011);
    set_modes(8'h00, 8'h00, 8'h01, 8'h00, 8'h00); rd("R1 oob low", 20'h10000);
    set_modes(8'h00, 8'h08, 8'h00, 8'h00, 8'h00); rd("R1 oob high", 20'h1FFFF);
    set_modes(8'h00, 8'h00, 8'h02, 8'h00, 8'h00); rd("R1 high bits", 20'hE0033);
    set_modes(8'h00, 8'h00, 8'h02, 8'h00, 8'h00); rd("R1 oob alias", 20'h31234);

    // R8 chain-4 / odd-even keep latch
    set_modes(8'h00, 8'h00, 8'h00, 8'h00, 8'h00); rd("R8 load", 20'h00055);
    set_modes(8'h08, 8'h00, 8'h00, 8'h00, 8'h00); rd("R8 chain4 keep", 20'h00301);
    set_modes(8'h00, 8'h10, 8'h00, 8'h00, 8'h00); rd("R8 oddeven keep", 20'h00301);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] s4, g5;
      logic [ADDR_W-1:0] a;
      s4 = ($urandom % 4 == 0) ? 8'h08 : 8'($urandom) & 8'hF7;
      g5 = 8'($urandom);
      if ($urandom % 3 == 0) g5[4] = 1'b0;
      a = $urandom;
      if ($urandom % 8 != 0) a[16] = 1'b0;
      set_modes(s4, g5, 8'($urandom), 8'($urandom), 8'($urandom));
      rd("R2 R3 R4 R5 R6 random", a);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule